// File: doc/BRIEF.md
# Spare-Lane Steering Control for a Six-Channel Receiver

This block decides which of seven serial inputs feeds each of six receiver channels. Inputs 0 to 5 are the primary lanes and input 6 is a spare. A registered 3-bit select picks one primary channel for the spare to serve. The primary lane that the spare displaces is sent, undecoded, to a low-speed monitor output, so a technician can watch the lane that was taken out of service. Two select codes leave the spare unused. One of them silences the monitor. The other puts the spare lane itself on the monitor.

The block also produces one drive-enable for every tri-stated output: receiver data, recovered clock, lock and monitor. A power-up control gates all of these enables. An output-enable control gates data, clock and monitor, but leaves lock reporting active. A monitor-enable input passes through a short pipeline before it reaches the monitor's drive-enable.

Top module: `steer_ctrl`

## Requirements
- R1: When the registered select holds a value n from 0 to 5, receiver input `rx_in[n]` equals `ser_in[6]`, and `mon_out` equals `ser_in[n]`.
- R2: Every receiver channel that the spare does not replace receives its own lane, so `rx_in[c]` equals `ser_in[c]`.
- R3: With select 6, the spare is unused, every receiver takes its own lane, `mon_out` is 0 and `mon_oe` is low.
- R4: With select 7, the spare is unused, every receiver takes its own lane, and `mon_out` equals `ser_in[6]`.
- R5: A new value on `sel_in` changes the routing only after the next rising clock edge. Before that edge the routing stays as it was.
- R6: Reset loads the select register with 7, which matches the state of select pins that are left undriven and pulled high.
- R7: While `pwr_up` is low, every bit of `data_oe`, `clk_oe` and `lock_oe`, and `mon_oe`, is low, whatever the select value.
- R8: While `pwr_up` is high and `out_en` is low, `data_oe`, `clk_oe` and `mon_oe` are low, and every bit of `lock_oe` is high. When both controls are high, `data_oe` and `clk_oe` are all ones.
- R9: A change on `mon_en` reaches `mon_oe` after two rising clock edges. `mon_oe` is high only when the delayed enable, `pwr_up` and `out_en` are all high and the select is not 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_up | input | 1 | Low powers the block down and releases every output |
| out_en | input | 1 | Low releases the data, clock and monitor outputs |
| mon_en | input | 1 | Monitor enable, applied after a two-edge delay |
| sel_in | input | 3 | Spare-lane select: 0-5 replace that channel, 6 monitor off, 7 spare to monitor |
| ser_in | input | 7 | Serial lanes, bit 6 is the spare |
| rx_in | output | 6 | Lane delivered to each receiver channel |
| mon_out | output | 1 | Undecoded lane shown on the monitor |
| mon_oe | output | 1 | Drive-enable for the monitor output |
| data_oe | output | 6 | Drive-enable for each channel's data outputs |
| clk_oe | output | 6 | Drive-enable for each channel's clock output |
| lock_oe | output | 6 | Drive-enable for each channel's lock output |

## Verification
The hardest conditions to reach from the ports combine three things at once: the two-edge monitor pipeline is in mid-flight, the select has changed on the same edge, and power or output enable is also changing. Any one of them can hide the effect of the others. The directed tasks separate these effects. They raise and lower `mon_en` and check `mon_oe` after one edge and again after two. They change `sel_in` and check the routing between the drive and the edge. They keep `mon_en` high while the select moves to 6 and while `pwr_up` or `out_en` drops, so that each gating term is shown to override the delayed enable.

// File: rtl/steer_pkg.sv
package steer_pkg;

  localparam int STEER_NPRI = 6;

  // Which input lane feeds receiver channel ch for a given select code.
  function automatic int rx_src_idx(int ch, int sel, int npri);
    return (sel == ch) ? npri : ch;
  endfunction

  // Which input lane is shown on the monitor. Returns -1 when the monitor is silent.
  function automatic int mon_src_idx(int sel, int npri);
    if (sel < npri)       return sel;
    else if (sel == npri) return -1;
    else                  return npri;
  endfunction

endpackage

// File: rtl/steer_sel_reg.sv
module steer_sel_reg #(
  parameter int SEL_W     = 3,
  parameter int RESET_SEL = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_d,
  output logic [SEL_W-1:0] sel_q
);
  localparam logic [SEL_W-1:0] RST_VAL = SEL_W'(RESET_SEL);

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= RST_VAL;
    else        sel_q <= sel_d;
  end
endmodule

// File: rtl/steer_route.sv
module steer_route
  import steer_pkg::*;
#(
  parameter int N_PRI = 6,
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0] sel_q,
  input  logic [N_PRI:0]   ser_in,
  output logic [N_PRI-1:0] rx_in,
  output logic             mon_out,
  output logic             mon_live
);
  for (genvar ch = 0; ch < N_PRI; ch++) begin : g_chan
    always_comb begin
      rx_in[ch] = 1'b0;
      for (int k = 0; k <= N_PRI; k++)
        if (k == rx_src_idx(ch, int'(sel_q), N_PRI)) rx_in[ch] = ser_in[k];
    end
  end

  always_comb begin
    mon_out  = 1'b0;
    mon_live = (mon_src_idx(int'(sel_q), N_PRI) >= 0);
    for (int k = 0; k <= N_PRI; k++)
      if (k == mon_src_idx(int'(sel_q), N_PRI)) mon_out = ser_in[k];
  end
endmodule

// File: rtl/steer_oe_ctrl.sv
module steer_oe_ctrl #(
  parameter int N_PRI   = 6,
  parameter int MON_DLY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_up,
  input  logic             out_en,
  input  logic             mon_en,
  input  logic             mon_live,
  output logic             mon_en_dly,
  output logic             mon_oe,
  output logic [N_PRI-1:0] data_oe,
  output logic [N_PRI-1:0] clk_oe,
  output logic [N_PRI-1:0] lock_oe
);
  logic [MON_DLY-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[MON_DLY-2:0], mon_en};
  end

  assign mon_en_dly = pipe_q[MON_DLY-1];

  logic drive_ok;
  assign drive_ok = pwr_up & out_en;

  for (genvar ch = 0; ch < N_PRI; ch++) begin : g_oe
    assign data_oe[ch] = drive_ok;
    assign clk_oe[ch]  = drive_ok;
    assign lock_oe[ch] = pwr_up;
  end

  assign mon_oe = drive_ok & mon_en_dly & mon_live;
endmodule

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import steer_pkg::*;
#(
  parameter int N_PRI   = STEER_NPRI,
  parameter int MON_DLY = 2,
  localparam int SEL_W  = $clog2(N_PRI + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_up,
  input  logic             out_en,
  input  logic             mon_en,
  input  logic [SEL_W-1:0] sel_in,
  input  logic [N_PRI:0]   ser_in,
  output logic [N_PRI-1:0] rx_in,
  output logic             mon_out,
  output logic             mon_oe,
  output logic [N_PRI-1:0] data_oe,
  output logic [N_PRI-1:0] clk_oe,
  output logic [N_PRI-1:0] lock_oe
);
  logic [SEL_W-1:0] sel_q;
  logic             mon_live;
  logic             mon_en_dly;

  steer_sel_reg #(.SEL_W(SEL_W), .RESET_SEL(N_PRI + 1)) sel_reg_i (
    .clk(clk), .rst_n(rst_n), .sel_d(sel_in), .sel_q(sel_q)
  );

  steer_route #(.N_PRI(N_PRI), .SEL_W(SEL_W)) route_i (
    .sel_q(sel_q), .ser_in(ser_in), .rx_in(rx_in),
    .mon_out(mon_out), .mon_live(mon_live)
  );

  steer_oe_ctrl #(.N_PRI(N_PRI), .MON_DLY(MON_DLY)) oe_i (
    .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .out_en(out_en),
    .mon_en(mon_en), .mon_live(mon_live), .mon_en_dly(mon_en_dly),
    .mon_oe(mon_oe), .data_oe(data_oe), .clk_oe(clk_oe), .lock_oe(lock_oe)
  );
endmodule

// File: rtl/steer_ctrl_chk.sv
module steer_ctrl_chk #(
  parameter int N_PRI   = 6,
  parameter int MON_DLY = 2,
  parameter int SEL_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_up,
  input logic             out_en,
  input logic             mon_en,
  input logic [SEL_W-1:0] sel_in,
  input logic [SEL_W-1:0] sel_q,
  input logic [N_PRI:0]   ser_in,
  input logic [N_PRI-1:0] rx_in,
  input logic             mon_out,
  input logic             mon_oe,
  input logic             mon_en_dly,
  input logic [N_PRI-1:0] data_oe,
  input logic [N_PRI-1:0] clk_oe,
  input logic [N_PRI-1:0] lock_oe
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n)              since_rst <= 2'd0;
    else if (since_rst != 2) since_rst <= since_rst + 2'd1;
  end

  for (genvar ch = 0; ch < N_PRI; ch++) begin : g_ch
    assert_spare_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sel_q) == ch) |-> (rx_in[ch] == ser_in[N_PRI] && mon_out == ser_in[ch]));
    assert_own_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sel_q) != ch) |-> (rx_in[ch] == ser_in[ch]));
  end

  assert_mon_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel_q) == N_PRI) |-> (!mon_oe && !mon_out));

  assert_spare_mon_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel_q) == N_PRI + 1) |-> (mon_out == ser_in[N_PRI]));

  assert_sel_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2) |-> (sel_q == $past(sel_in)));

  assert_pwr_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_up |-> (data_oe == '0 && clk_oe == '0 && lock_oe == '0 && !mon_oe));

  assert_out_dis_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_up && !out_en) |-> (data_oe == '0 && clk_oe == '0 && !mon_oe && (&lock_oe)));

  assert_mon_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mon_oe |-> (mon_en_dly && pwr_up && out_en));

  if (MON_DLY == 2) begin : g_dly2
    assert_mon_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2) |-> (mon_en_dly == $past(mon_en, 2)));
  end
endmodule

bind steer_ctrl steer_ctrl_chk #(.N_PRI(N_PRI), .MON_DLY(MON_DLY), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .out_en(out_en), .mon_en(mon_en),
  .sel_in(sel_in), .sel_q(sel_q), .ser_in(ser_in), .rx_in(rx_in),
  .mon_out(mon_out), .mon_oe(mon_oe), .mon_en_dly(mon_en_dly),
  .data_oe(data_oe), .clk_oe(clk_oe), .lock_oe(lock_oe)
);

// File: tb/steer_ctrl_tb.sv
module steer_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, pwr_up, out_en, mon_en;
  logic [2:0] sel_in;
  logic [6:0] ser_in;
  logic [5:0] rx_in, data_oe, clk_oe, lock_oe;
  logic       mon_out, mon_oe;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  steer_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .out_en(out_en), .mon_en(mon_en),
    .sel_in(sel_in), .ser_in(ser_in), .rx_in(rx_in), .mon_out(mon_out),
    .mon_oe(mon_oe), .data_oe(data_oe), .clk_oe(clk_oe), .lock_oe(lock_oe)
  );

  function automatic logic [5:0] exp_rx(int s, logic [6:0] lanes);
    logic [5:0] r;
    r = lanes[5:0];
    if (s <= 5) r[s] = lanes[6];
    return r;
  endfunction

  function automatic logic exp_mon(int s, logic [6:0] lanes);
    if (s == 7) return lanes[6];
    if (s == 6) return 1'b0;
    return lanes[s];
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_sel(logic [2:0] s);
    @(negedge clk); sel_in = s; tick();
  endtask

  task automatic t_reset();
    rst_n = 0; pwr_up = 1; out_en = 1; mon_en = 0; sel_in = 3'd2; ser_in = 7'h4A;
    repeat (3) tick();
    check(rx_in == exp_rx(7, ser_in), "R6 rx at reset", rx_in, exp_rx(7, ser_in));
    check(mon_out == ser_in[6], "R6 mon at reset", mon_out, ser_in[6]);
    check(mon_oe == 1'b0, "R9 mon_oe at reset", mon_oe, 0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_replace();
    logic [6:0] pats [4] = '{7'h55, 7'h2A, 7'h40, 7'h3F};
    for (int s = 0; s < 6; s++) begin
      set_sel(3'(s));
      for (int p = 0; p < 4; p++) begin
        @(negedge clk); ser_in = pats[p]; #1;
        check(rx_in == exp_rx(s, ser_in), "R1 R2 rx routing", rx_in, exp_rx(s, ser_in));
        check(mon_out == exp_mon(s, ser_in), "R1 mon lane", mon_out, exp_mon(s, ser_in));
      end
    end
  endtask

  task automatic t_spare_idle();
    @(negedge clk); mon_en = 1; tick(); tick();
    set_sel(3'd6);
    ser_in = 7'h7F; #1;
    check(rx_in == 6'h3F, "R3 rx own", rx_in, 6'h3F);
    check(mon_out == 1'b0 && mon_oe == 1'b0, "R3 mon silent", {mon_out, mon_oe}, 0);
    set_sel(3'd7);
    ser_in = 7'h40; #1;
    check(rx_in == 6'h00, "R4 rx own", rx_in, 0);
    check(mon_out == 1'b1, "R4 spare on mon", mon_out, 1);
    check(mon_oe == 1'b1, "R9 mon_oe sel7", mon_oe, 1);
    ser_in = 7'h3F; #1;
    check(mon_out == 1'b0, "R4 spare low on mon", mon_out, 0);
  endtask

  task automatic t_sel_timing();
    set_sel(3'd7);
    @(negedge clk); ser_in = 7'h01; sel_in = 3'd0; #1;
    check(rx_in == 6'h01, "R5 before edge", rx_in, 6'h01);
    tick();
    check(rx_in == 6'h00, "R5 after edge", rx_in, 6'h00);
  endtask

  task automatic t_mon_delay();
    set_sel(3'd7);
    @(negedge clk); mon_en = 0; tick(); tick();
    check(mon_oe == 1'b0, "R9 settled low", mon_oe, 0);
    @(negedge clk); mon_en = 1;
    tick();
    check(mon_oe == 1'b0, "R9 one edge rise", mon_oe, 0);
    tick();
    check(mon_oe == 1'b1, "R9 two edges rise", mon_oe, 1);
    @(negedge clk); mon_en = 0;
    tick();
    check(mon_oe == 1'b1, "R9 one edge fall", mon_oe, 1);
    tick();
    check(mon_oe == 1'b0, "R9 two edges fall", mon_oe, 0);
  endtask

  task automatic t_power();
    @(negedge clk); mon_en = 1; tick(); tick();
    for (int s = 0; s < 8; s++) begin
      set_sel(3'(s));
      @(negedge clk); pwr_up = 0; #1;
      check(data_oe == 0 && clk_oe == 0 && lock_oe == 0 && mon_oe == 0,
            "R7 power down", {data_oe, clk_oe, lock_oe, mon_oe}, 0);
      pwr_up = 1;
    end
    @(negedge clk); out_en = 0; #1;
    check(data_oe == 0 && clk_oe == 0 && mon_oe == 0, "R8 outputs off",
          {data_oe, clk_oe, mon_oe}, 0);
    check(lock_oe == 6'h3F, "R8 lock stays", lock_oe, 6'h3F);
    out_en = 1; #1;
    check(data_oe == 6'h3F && clk_oe == 6'h3F, "R8 outputs on", {data_oe, clk_oe}, 12'hFFF);
  endtask

  initial begin
    t_reset();
    t_replace();
    t_spare_idle();
    t_sel_timing();
    t_mon_delay();
    t_power();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule